// File: doc/BRIEF.md
# Autopoll Round-Robin Address Selector

This block decides which peripheral address a serial desktop-bus host should poll next when no host request is waiting. It samples a 16-bit enrollment mask, the last Talk Register 0 command that was issued, the last command of any kind, and a flag saying that some device has asked for service. From these it forms a single Talk Register 0 command byte and presents it with a one-cycle valid pulse.

Selection is sticky. The host keeps polling the same address until one of two things happens: another device asks for service while the bus is still repeating that poll, or the address is dropped from the mask. Then it moves to the next higher enrolled address and wraps to the lowest one. If the resulting byte is the same as the command the transceiver last sent, no poll is produced, because the transceiver already repeats that command by itself while idle.

The output stream has a valid strobe and no ready input. The consumer must take the byte in the cycle where `cmd_valid` is high. Back-pressure is not supported, and a poll that is not taken is not held.

Top module: `apoll_selector`

## Requirements
- R1: Mask bit 0 is ignored: address 0 is never emitted, and a mask with only bit 0 set behaves as an empty mask.
- R2: When the enrolled mask (bits 15:1) is empty, `cmd_valid` stays low.
- R3: The current candidate address is bits 7:4 of `last_poll_cmd`. It is kept when that address is enrolled and no move condition holds.
- R4: When `srq_seen` is high and `last_cmd` equals `last_poll_cmd`, the selector moves to the lowest enrolled address strictly above the candidate.
- R5: When `srq_seen` is high but `last_cmd` differs from `last_poll_cmd`, the candidate is kept if it is enrolled.
- R6: When the candidate address is not enrolled, the selector moves to the lowest enrolled address strictly above it.
- R7: When moving and no enrolled address lies above the candidate, the selector wraps to the lowest enrolled address. This may be the candidate itself.
- R8: The emitted byte carries the address in bits 7:4 and the Talk Register 0 code 4'b1100 in bits 3:0.
- R9: When the computed byte equals `last_cmd`, `cmd_valid` stays low.
- R10: Inputs are sampled on a rising edge where `poll_req` is high. `cmd_valid` is high for exactly the following cycle and never without such a request. Both `cmd_valid` and the request stage are cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_req | input | 1 | Sample the inputs and evaluate a poll |
| enroll_mask | input | 16 | Bit n enrolls address n (bit 0 ignored) |
| last_poll_cmd | input | 8 | Most recent Talk Register 0 command issued |
| last_cmd | input | 8 | Most recent command of any kind issued |
| srq_seen | input | 1 | A service request was observed |
| cmd_valid | output | 1 | One-cycle strobe: `cmd_byte` is a poll to issue |
| cmd_byte | output | 8 | Selected Talk Register 0 command |

## Verification
The selector is exercised with these patterns:
- Masks that hold the candidate steady, which separates "stay" from "move".
- A service request with matching and with mismatching last commands, which isolates the condition that joins the two comparisons.
- Masks that drop the candidate, or that hold nothing above it, which separates forward scanning from wrap-around, including a wrap back onto the candidate itself.
- Empty and bit-0-only masks, repeated commands and idle cycles without a request, which show that each suppression path is independent.

A long random run then compares every cycle against a behavioural model.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] TALK_R0_CODE = 4'b1100;
endpackage

// File: rtl/apoll_sample.sv
module apoll_sample #(
  parameter int ADDR_W  = 4,
  parameter int NUM_DEV = 1 << ADDR_W,
  parameter int CMD_W   = ADDR_W + apoll_pkg::OP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poll_req,
  input  logic [NUM_DEV-1:0] enroll_mask,
  input  logic [CMD_W-1:0]   last_poll_cmd,
  input  logic [CMD_W-1:0]   last_cmd,
  input  logic               srq_seen,
  output logic               req_q,
  output logic [NUM_DEV-1:0] mask_q,
  output logic [CMD_W-1:0]   lpoll_q,
  output logic [CMD_W-1:0]   lcmd_q,
  output logic               srq_q
);
  // the strobe is reset; the data registers only load on a request
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= poll_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      lpoll_q <= '0;
      lcmd_q  <= '0;
      srq_q   <= 1'b0;
    end else if (poll_req) begin
      mask_q  <= enroll_mask & ~NUM_DEV'(1);  // address 0 never enrolled
      lpoll_q <= last_poll_cmd;
      lcmd_q  <= last_cmd;
      srq_q   <= srq_seen;
    end
  end
endmodule

// File: rtl/apoll_lowest.sv
module apoll_lowest #(
  parameter int ADDR_W  = 4,
  parameter int NUM_DEV = 1 << ADDR_W
) (
  input  logic [NUM_DEV-1:0] vec,
  output logic               any,
  output logic [ADDR_W-1:0]  idx
);
  logic [NUM_DEV-1:0] below;
  logic [NUM_DEV-1:0] first;

  assign below[0] = 1'b0;
  genvar i;
  generate
    for (i = 1; i < NUM_DEV; i++) begin : g_chain
      assign below[i] = below[i-1] | vec[i-1];
    end
  endgenerate

  assign first = vec & ~below;
  assign any   = |vec;

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_DEV; k++)
      if (first[k]) idx = idx | ADDR_W'(k);
  end
endmodule

// File: rtl/apoll_pick.sv
module apoll_pick #(
  parameter int ADDR_W  = 4,
  parameter int NUM_DEV = 1 << ADDR_W,
  parameter int CMD_W   = ADDR_W + apoll_pkg::OP_W
) (
  input  logic [NUM_DEV-1:0] mask,
  input  logic [CMD_W-1:0]   lpoll,
  input  logic [CMD_W-1:0]   lcmd,
  input  logic               srq,
  output logic               have_dev,
  output logic [ADDR_W-1:0]  sel_addr
);
  localparam int OP_W = apoll_pkg::OP_W;

  logic [ADDR_W-1:0]  cur;
  logic [NUM_DEV-1:0] above;
  logic [NUM_DEV-1:0] higher;
  logic               cur_enrolled, move;
  logic               hi_any, all_any;
  logic [ADDR_W-1:0]  hi_idx, all_idx;

  assign cur = lpoll[CMD_W-1:OP_W];

  genvar i;
  generate
    for (i = 0; i < NUM_DEV; i++) begin : g_above
      assign above[i] = (ADDR_W+1)'(i) > {1'b0, cur};
    end
  endgenerate

  assign higher       = mask & above;
  assign cur_enrolled = mask[cur];
  assign move         = (srq && (lcmd == lpoll)) || !cur_enrolled;

  apoll_lowest #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) u_hi (
    .vec(higher), .any(hi_any), .idx(hi_idx)
  );
  apoll_lowest #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) u_all (
    .vec(mask), .any(all_any), .idx(all_idx)
  );

  assign have_dev = all_any;

  always_comb begin
    if (!move)       sel_addr = cur;
    else if (hi_any) sel_addr = hi_idx;
    else             sel_addr = all_idx;
  end
endmodule

// File: rtl/apoll_selector.sv
module apoll_selector #(
  parameter int ADDR_W  = 4,
  parameter int NUM_DEV = 1 << ADDR_W,
  parameter int CMD_W   = ADDR_W + apoll_pkg::OP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poll_req,
  input  logic [NUM_DEV-1:0] enroll_mask,
  input  logic [CMD_W-1:0]   last_poll_cmd,
  input  logic [CMD_W-1:0]   last_cmd,
  input  logic               srq_seen,
  output logic               cmd_valid,
  output logic [CMD_W-1:0]   cmd_byte
);
  logic               req_q, srq_q, have_dev;
  logic [NUM_DEV-1:0] mask_q;
  logic [CMD_W-1:0]   lpoll_q, lcmd_q;
  logic [ADDR_W-1:0]  sel_addr;

  apoll_sample #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .CMD_W(CMD_W)) u_sample (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req),
    .enroll_mask(enroll_mask), .last_poll_cmd(last_poll_cmd),
    .last_cmd(last_cmd), .srq_seen(srq_seen),
    .req_q(req_q), .mask_q(mask_q), .lpoll_q(lpoll_q),
    .lcmd_q(lcmd_q), .srq_q(srq_q)
  );

  apoll_pick #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .CMD_W(CMD_W)) u_pick (
    .mask(mask_q), .lpoll(lpoll_q), .lcmd(lcmd_q), .srq(srq_q),
    .have_dev(have_dev), .sel_addr(sel_addr)
  );

  // suppress polls to nobody and polls that repeat the last command
  assign cmd_byte  = {sel_addr, apoll_pkg::TALK_R0_CODE};
  assign cmd_valid = req_q && have_dev && (cmd_byte != lcmd_q);
endmodule

// File: rtl/apoll_sel_chk.sv
module apoll_sel_chk #(
  parameter int ADDR_W  = 4,
  parameter int NUM_DEV = 1 << ADDR_W,
  parameter int CMD_W   = ADDR_W + apoll_pkg::OP_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               poll_req,
  input logic [NUM_DEV-1:0] enroll_mask,
  input logic [CMD_W-1:0]   last_cmd,
  input logic               cmd_valid,
  input logic [CMD_W-1:0]   cmd_byte
);
  localparam int OP_W = apoll_pkg::OP_W;

  p_no_addr0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_byte[CMD_W-1:OP_W] != '0);

  p_empty_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(enroll_mask) & ~NUM_DEV'(1)) != '0);

  p_enrolled_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (($past(enroll_mask) >> cmd_byte[CMD_W-1:OP_W]) & NUM_DEV'(1)) != '0);

  p_talk_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_byte[OP_W-1:0] == apoll_pkg::TALK_R0_CODE);

  p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_byte != $past(last_cmd));

  p_req_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(poll_req));
endmodule

bind apoll_selector apoll_sel_chk #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .enroll_mask(enroll_mask),
  .last_cmd(last_cmd), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte)
);

// File: tb/tb_apoll_selector.sv
`timescale 1ns/1ps
module tb_apoll_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_req = 1'b0;
  logic [15:0] enroll_mask = '0;
  logic [7:0]  last_poll_cmd = '0;
  logic [7:0]  last_cmd = '0;
  logic        srq_seen = 1'b0;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  apoll_selector dut (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .enroll_mask(enroll_mask),
    .last_poll_cmd(last_poll_cmd), .last_cmd(last_cmd), .srq_seen(srq_seen),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte)
  );

  // behavioural model of the requirements
  function automatic void model(input bit req, input int mask, input int lp,
                                input int lc, input bit srq,
                                output bit v, output int cmd);
    int m, cur, sel;
    bit mv;
    m = mask & 'hFFFE;               // R1
    v = 0; cmd = 0;
    if (!req || m == 0) return;      // R10, R2
    cur = (lp >> 4) & 15;            // R3
    mv = (srq && lc == lp) || (((m >> cur) & 1) == 0);
    sel = cur;
    if (mv) begin
      sel = -1;
      for (int a = cur + 1; a < 16; a++) if (sel < 0 && ((m >> a) & 1)) sel = a;
      for (int a = 1; a < 16; a++)       if (sel < 0 && ((m >> a) & 1)) sel = a;
    end
    cmd = sel * 16 + 12;             // R8
    v = (cmd != lc);                 // R9
  endfunction

  task automatic step(input bit r, input int m, input int lp, input int lc,
                      input bit s, input string tag);
    bit ev;
    int ec;
    poll_req = r; enroll_mask = 16'(m); last_poll_cmd = 8'(lp);
    last_cmd = 8'(lc); srq_seen = s;
    model(r, m, lp, lc, s, ev, ec);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (cmd_valid !== ev || (ev && cmd_byte !== 8'(ec))) begin
      fails++;
      $display("FAIL %s: valid=%0b cmd=%02h expected valid=%0b cmd=%02h",
               tag, cmd_valid, cmd_byte, ev, 8'(ec));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: valid=%0b expected 0", cmd_valid);
    end
    rst_n = 1'b1;

    step(1, 'h0000, 'h2C, 'h00, 0, "R2 empty mask");
    step(1, 'h0001, 'h0C, 'h00, 1, "R1 only bit0 enrolled");
    step(1, 'h0009, 'h0C, 'h5C, 0, "R1 address0 candidate moves to 3");
    step(1, 'h0024, 'h2C, 'h5C, 0, "R3 stay on enrolled candidate");
    step(0, 'h0024, 'h2C, 'h5C, 0, "R10 no request no strobe");
    step(1, 'h0024, 'h2C, 'h2C, 0, "R9 repeat suppressed");
    step(1, 'h0024, 'h2C, 'h2C, 1, "R4 service request moves up");
    step(1, 'h0024, 'h2C, 'h3F, 1, "R5 service request mismatched last cmd");
    step(1, 'h0030, 'h2C, 'h2C, 0, "R6 candidate removed");
    step(1, 'h0006, 'h2C, 'h2C, 1, "R7 wrap to lowest");
    step(1, 'h8000, 'hFC, 'h00, 1, "R5 top address kept");
    step(1, 'h8000, 'hFC, 'hFC, 1, "R7 R9 wrap onto itself suppressed");
    step(1, 'h8002, 'hFC, 'hFC, 1, "R7 wrap from top to 1");
    step(1, 'hFFFE, 'h7C, 'h7C, 1, "R4 R8 full mask next higher");
    step(0, 'hFFFE, 'h7C, 'h00, 1, "R10 strobe lasts one cycle");

    for (int n = 0; n < 400; n++) begin
      int m, lp, lc;
      bit r, s;
      m  = (n % 5 == 0) ? int'($urandom_range(0, 3)) : int'($urandom & 'hFFFF);
      lp = int'($urandom_range(0, 15)) * 16 + 12;
      lc = ($urandom_range(0, 2) == 0) ? int'($urandom & 'hFF) : lp;
      r  = ($urandom_range(0, 3) != 0);
      s  = $urandom_range(0, 1) == 1;
      step(r, m, lp, lc, s, "R3 R4 R6 R7 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule